// File: doc/BRIEF.md
# Oversampled SPI Slave

This block is an SPI slave that lives entirely in a fast system clock domain. The serial clock, the select line and the incoming data line are all treated as asynchronous signals: each one passes through a synchronizer. Clock transitions are then found by comparing successive samples, so the serial clock never clocks a flop. The serial clock must stay high for more than two system cycles, and low for more than two system cycles, for its edges to be seen. In practice a few more cycles of margin are advisable.

On the system side, a write strobe loads the next byte to transmit, and a read strobe acknowledges the received byte. A held receive buffer presents the last complete byte. A completion flag and a maskable interrupt request report each finished byte. On the line side, the outgoing data pin is driven only while the slave is selected, and is high impedance otherwise. The block uses one fixed clock mode. The serial clock idles low, incoming bits are captured on its rising edge, outgoing bits change on its falling edge, and the most significant bit goes first.

Control sits in a two-state machine:
- `ST_IDLE` is the deselected state. The transmit byte is copied into the shifter on the cycle the synchronized select is seen low.
- `ST_SHIFT` is the active state.

There are two transitions:
- The select-fall transition goes from `ST_IDLE` to `ST_SHIFT`.
- The select-rise transition goes from `ST_SHIFT` back to `ST_IDLE`. It clears the bit counter and throws away any partial byte.

Top module: `spi_slave_os`

## Requirements
- R1: After reset, `done_flag`, `irq` and `rx_data` are all zero and `miso` is high impedance.
- R2: `miso` is high impedance whenever `ss_n` is high, and is driven while `ss_n` is low.
- R3: While `ss_n` is high, pulses on `sck` capture nothing: `rx_data` keeps its value and `done_flag` stays 0.
- R4: A byte written while deselected has its most significant bit on `miso` after `ss_n` falls, before the first rising edge of `sck`.
- R5: `mosi` is sampled on each rising `sck` edge, most significant bit first. After eight rising edges, `rx_data` holds the eight sampled bits.
- R6: `miso` advances to the next bit on each falling `sck` edge, so a master sampling on rising edges reads the transmit byte most significant bit first.
- R7: `done_flag` is set when the eighth bit of a byte is captured, and is cleared by a pulse on `rx_rd`. If both happen in the same cycle, setting wins.
- R8: `irq` is high exactly when `done_flag` is high and `irq_en` is 1.
- R9: A byte written with `tx_wr` during a transfer is sent as the following byte, starting at the falling edge that ends the current byte.
- R10: If a second byte completes before `rx_rd`, `rx_data` is overwritten with the second byte and `done_flag` remains 1.
- R11: If `ss_n` rises before eight bits are captured, the partial byte is dropped, `done_flag` is not set, and the next selection starts a fresh byte from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from master, asynchronous |
| ss_n | input | 1 | Active-low slave select, asynchronous |
| mosi | input | 1 | Serial data from master, asynchronous |
| miso | output | 1 | Serial data to master, high impedance when deselected |
| tx_wr | input | 1 | One-cycle strobe loading `tx_data` as the next byte to send |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | One-cycle strobe acknowledging the received byte |
| rx_data | output | 8 | Last complete received byte |
| irq_en | input | 1 | Interrupt enable |
| done_flag | output | 1 | Byte-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
A stuck state machine appears at `miso` within three system cycles of a select change. The pin either stays high impedance while selected or keeps driving after deselect. A bit counter that is off by one shows up at the end of the same byte. `rx_data` then comes out shifted by one place, `done_flag` rises one `sck` period early or late, and the next byte's first `miso` bit is wrong. A transmit shifter that misses its reload at a byte boundary resends stale data. That error is visible on the first bit of the following byte.

// File: rtl/spis_pkg.sv
package spis_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } spis_state_e;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int              W      = 1,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RSTV   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RSTV;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge #(
    parameter logic RSTV = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RSTV;
        else        prev_q <= d;
    end

    assign rise = d & ~prev_q;
    assign fall = ~d & prev_q;
endmodule

// File: rtl/spi_slave_os.sv
module spi_slave_os
    import spis_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          ss_n,
    input  logic          mosi,
    output logic          miso,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_data,
    input  logic          irq_en,
    output logic          done_flag,
    output logic          irq
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic [2:0] line_s;
    logic       ss_s, sck_s, mosi_s;
    logic       sck_rise, sck_fall;

    spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RSTV(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ss_n, sck, mosi}),
        .q    (line_s)
    );
    assign ss_s   = line_s[2];
    assign sck_s  = line_s[1];
    assign mosi_s = line_s[0];

    spis_edge #(.RSTV(1'b0)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sck_s),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    spis_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] tx_q, tx_sh, rx_buf_q;
    logic [DW-2:0] rx_sh;
    logic          flag_q;
    logic [DW-1:0] tx_next;
    logic          shift_go, byte_done, miso_oe;

    assign tx_next   = tx_wr ? tx_data : tx_q;
    assign shift_go  = (st_q == ST_SHIFT) && !ss_s;
    assign byte_done = shift_go && sck_rise && (cnt_q == LAST_BIT);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (!ss_s) st_d = ST_SHIFT;
            ST_SHIFT: if (ss_s)  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_buf_q <= '0;
            cnt_q    <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (tx_wr) tx_q <= tx_data;

            if (st_q == ST_IDLE) begin
                cnt_q <= '0;
                if (!ss_s) tx_sh <= tx_next;
            end else if (ss_s) begin
                cnt_q <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sh <= {rx_sh[DW-3:0], mosi_s};
                    cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
                    if (byte_done) rx_buf_q <= {rx_sh, mosi_s};
                end
                if (sck_fall) begin
                    if (cnt_q == '0) tx_sh <= tx_next;
                    else             tx_sh <= {tx_sh[DW-2:0], 1'b0};
                end
            end

            if (byte_done)  flag_q <= 1'b1;
            else if (rx_rd) flag_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        miso_oe   = (st_q == ST_SHIFT);
        done_flag = flag_q;
        irq       = flag_q & irq_en;
        rx_data   = rx_buf_q;
    end
    assign miso = miso_oe ? tx_sh[DW-1] : 1'bz;

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> $stable(rx_buf_q));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_go && sck_rise && cnt_q != LAST_BIT) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> done_flag);

    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !byte_done) |=> !done_flag);

    // R11
    abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && ss_s) |=> (st_q == ST_IDLE && cnt_q == '0));
endmodule

// File: tb/sim_spi_slave_os.sv
`timescale 1ns/1ps
module sim_spi_slave_os;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    wire        miso;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, irq_en = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       done_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_slave_os u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .irq_en(irq_en), .done_flag(done_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] v);
        @(negedge clk); tx_wr = 1'b1; tx_data = v;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
        wait_clk(2);
    endtask

    task automatic select();
        @(negedge clk); ss_n = 1'b0; wait_clk(8);
    endtask

    task automatic deselect();
        @(negedge clk); ss_n = 1'b1; wait_clk(8);
    endtask

    // master side: n bits, optional tx write after the fourth bit
    task automatic shift_bits(input logic [7:0] b, input int n, input bit do_wr,
                              input logic [7:0] wv, output logic [7:0] got);
        got = '0;
        for (int i = 7; i >= 8 - n; i--) begin
            mosi = b[i];
            wait_clk(8);
            got[i] = miso;
            sck = 1'b1;
            wait_clk(8);
            sck = 1'b0;
            if (do_wr && i == 4) write_tx(wv);
        end
        wait_clk(8);
    endtask

    task automatic t_reset();
        chk("R1 flag", {7'b0, done_flag}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1/R2 miso z", {7'b0, miso}, {7'b0, 1'bz});
    endtask

    task automatic t_idle_ignored();
        logic [7:0] got;
        write_tx(8'h5A);
        mosi = 1'b1;
        for (int k = 0; k < 8; k++) begin
            sck = 1'b1; wait_clk(8); sck = 1'b0; wait_clk(8);
        end
        chk("R3 flag", {7'b0, done_flag}, 8'h00);
        chk("R3 rx_data", rx_data, 8'h00);
        chk("R2 miso z idle", {7'b0, miso}, {7'b0, 1'bz});
        select();
        chk("R4 first bit", {7'b0, miso}, 8'h00);
        shift_bits(8'h81, 8, 1'b0, 8'h00, got);
        chk("R6 miso byte", got, 8'h5A);
        chk("R5 rx byte", rx_data, 8'h81);
        chk("R7 flag set", {7'b0, done_flag}, 8'h01);
        read_rx();
        chk("R7 flag clr", {7'b0, done_flag}, 8'h00);
        deselect();
        chk("R2 miso z after", {7'b0, miso}, {7'b0, 1'bz});
    endtask

    task automatic t_basic();
        logic [7:0] got;
        write_tx(8'hA5);
        select();
        chk("R4 first bit", {7'b0, miso}, 8'h01);
        shift_bits(8'h3C, 8, 1'b0, 8'h00, got);
        chk("R6 miso byte", got, 8'hA5);
        chk("R5 rx byte", rx_data, 8'h3C);
        read_rx();
        deselect();
    endtask

    task automatic t_irq();
        logic [7:0] got;
        irq_en = 1'b0;
        select();
        shift_bits(8'h77, 8, 1'b0, 8'h00, got);
        chk("R8 masked flag", {7'b0, done_flag}, 8'h01);
        chk("R8 masked irq", {7'b0, irq}, 8'h00);
        irq_en = 1'b1;
        wait_clk(1);
        chk("R8 irq on", {7'b0, irq}, 8'h01);
        read_rx();
        chk("R8 irq off", {7'b0, irq}, 8'h00);
        irq_en = 1'b0;
        deselect();
    endtask

    task automatic t_next_tx();
        logic [7:0] got;
        write_tx(8'h11);
        select();
        shift_bits(8'hF0, 8, 1'b1, 8'h22, got);
        chk("R9 first byte out", got, 8'h11);
        chk("R5 first byte in", rx_data, 8'hF0);
        shift_bits(8'h0F, 8, 1'b0, 8'h00, got);
        chk("R9 next byte out", got, 8'h22);
        chk("R10 overwritten", rx_data, 8'h0F);
        chk("R10 flag held", {7'b0, done_flag}, 8'h01);
        read_rx();
        deselect();
    endtask

    task automatic t_abort();
        logic [7:0] got;
        write_tx(8'h99);
        select();
        shift_bits(8'hFF, 4, 1'b0, 8'h00, got);
        deselect();
        chk("R11 no flag", {7'b0, done_flag}, 8'h00);
        chk("R11 rx kept", rx_data, 8'h0F);
        select();
        shift_bits(8'hC3, 8, 1'b0, 8'h00, got);
        chk("R11 fresh out", got, 8'h99);
        chk("R11 fresh in", rx_data, 8'hC3);
        chk("R11 flag", {7'b0, done_flag}, 8'h01);
        read_rx();
        deselect();
    endtask

    initial begin
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_idle_ignored();
        t_basic();
        t_irq();
        t_next_tx();
        t_abort();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule